// File: doc/BRIEF.md
# Four-Way Instruction Cache Tag Store with Pairwise Recency

This block holds the tag, state and replacement information of a 16 Kbyte instruction cache with four ways per set, 256 sets and lines of four 32-bit words. A lookup presents a 32-bit effective address and the 20-bit physical tag that the translation unit produced for it. One clock later the block reports whether a valid line in the indexed set carries that tag, which way it sits in, and which way a refill should replace. A separate fill port writes a whole line together with its tag. A command port locks, unlocks or invalidates a single line. A debug port reads back either a line's tag and state or one data word.

Replacement keeps six recency bits per set, one for each pair of ways. Every hit and every fill makes the touched way newer than the other three. The victim is chosen only among unlocked ways: an empty one if any exists, otherwise the oldest. When all four ways of a set are locked, the block reports that nothing can be allocated.

Top module: `icache_tag_store`

## Requirements
- R1: After reset every line is invalid and unlocked, every tag is zero, every set's recency code is zero, and all outputs are zero.
- R2: Address bit positions are counted with 0 as the least significant bit. A lookup takes its set from address bits [11:4]. Address bits [31:12] and [3:0] have no effect on the lookup. The tag compared is always `lk_ptag`.
- R3: `lk_done` rises exactly one cycle after `lk_valid`. `lk_hit` is 1 only when a valid way of the set holds `lk_ptag`. `lk_hit_way` gives the lowest such way, and is 0 on a miss.
- R4: Recency code bits: bit 0 = way1 newer than way0, bit 1 = way2 over way0, bit 2 = way2 over way1, bit 3 = way3 over way0, bit 4 = way3 over way1, bit 5 = way3 over way2. A hit or a fill makes the touched way newer than all three others and leaves the order of the other three unchanged. All-zero means the order way0 (newest), way1, way2, way3.
- R5: The victim is the lowest-numbered way that is both unlocked and invalid, if any such way exists.
- R6: Otherwise the victim is the least recent unlocked way. A locked way is never the victim.
- R7: When all four ways of the set are locked, `lk_noalloc` is 1 and `lk_victim` is 0.
- R8: Command codes on `cmd_op`: 1 locks the line, 2 unlocks it, 3 invalidates it (clears valid and lock), 0 does nothing. A command takes effect for lookups in the following cycle. A command in the same cycle as a fill to the same line is applied after the fill.
- R9: A fill writes the tag and the line, sets valid and clears lock. A fill takes effect for lookups in the following cycle.
- R10: A debug read is `dbg_cmd` = {sel[12], way[11:10], set[9:2], word[1:0]}. `dbg_done` rises one cycle after `dbg_valid`. For sel=0, `dbg_rdata` = {tag[31:12], 2'b00, valid[9], lock[8], 2'b00, recency code[5:0]}.
- R11: For sel=1, `dbg_rdata` is the data word chosen by `word`. Word 0 is `fill_line[31:0]` and word 3 is `fill_line[127:96]`.
- R12: Work in one cycle on the same set is handled as follows. A lookup and a debug read see the state from before that cycle's fill and command. If a hit and a fill touch the same set, the hit is applied first and the fill second, so the filled way ends up newest and the hit way second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup effective address |
| lk_ptag | input | 20 | Physical tag of the lookup |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_hit_way | output | 2 | Way that hit |
| lk_victim | output | 2 | Replacement way for the looked-up set |
| lk_noalloc | output | 1 | All ways of the set locked |
| fill_valid | input | 1 | Fill request |
| fill_set | input | 8 | Set to fill |
| fill_way | input | 2 | Way to fill |
| fill_tag | input | 20 | Tag to store |
| fill_line | input | 128 | Line data, word 0 in the low bits |
| cmd_valid | input | 1 | Line command request |
| cmd_op | input | 2 | 0 none, 1 lock, 2 unlock, 3 invalidate |
| cmd_set | input | 8 | Command set |
| cmd_way | input | 2 | Command way |
| dbg_valid | input | 1 | Debug read request |
| dbg_cmd | input | 13 | Debug select, way, set, word |
| dbg_done | output | 1 | Debug data valid |
| dbg_rdata | output | 32 | Debug read data |

## Verification
The critical overlap is a lookup and a fill that hit the same set in the same cycle. This happens whenever a refill lands while the fetch stream keeps looking up. The bench provokes it on purpose: a lookup hits one way while a fill replaces a different way of that set. In a second case the fill overwrites the very way being hit. The lookup must report the old contents, the next lookup must see the new tag, and a tag read must show the fill way newest with the hit way second. A randomized phase then mixes lookups, fills, commands and debug reads on four sets, and compares each result against a model in the bench that keeps a per-set age rank instead of pair bits.

// File: rtl/ictag_pkg.sv
package ictag_pkg;
  localparam int SETS    = 256;
  localparam int WAYS    = 4;
  localparam int TAG_W   = 20;
  localparam int WORD_W  = 32;
  localparam int WORDS   = 4;
  localparam int LINE_W  = WORD_W * WORDS;
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int WSEL_W  = $clog2(WORDS);
  localparam int LRU_W   = WAYS * (WAYS - 1) / 2;
  localparam int DBG_W   = 1 + WAY_W + SET_W + WSEL_W;
  localparam int ADDR_W  = 32;
  localparam int SET_LSB = $clog2(LINE_W / 8);

  typedef logic [LRU_W-1:0] lru_t;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LOCK   = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_INVAL  = 2'd3
  } line_op_e;

  // bit position of the pair (hi over lo), hi > lo
  function automatic int pair_pos(int hi, int lo);
    return hi * (hi - 1) / 2 + lo;
  endfunction

  // 1 when way x is more recent than way y
  function automatic logic way_newer(lru_t c, int x, int y);
    if (x == y) return 1'b0;
    if (x > y) return c[pair_pos(x, y)];
    return !c[pair_pos(y, x)];
  endfunction

  // make way w newer than every other way
  function automatic lru_t lru_touch(lru_t c, int w);
    lru_t r;
    r = c;
    for (int a = 1; a < WAYS; a++)
      for (int b = 0; b < a; b++) begin
        if (a == w) r[pair_pos(a, b)] = 1'b1;
        else if (b == w) r[pair_pos(a, b)] = 1'b0;
      end
    return r;
  endfunction

  // way w is newer than every way except skip
  function automatic logic beats_all_but(lru_t c, int w, int skip);
    logic ok;
    ok = 1'b1;
    for (int o = 0; o < WAYS; o++)
      if (o != w && o != skip && !way_newer(c, w, o)) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/ictag_lines.sv
module ictag_lines
  import ictag_pkg::*;
#(
  parameter int N_SETS = SETS,
  parameter int N_WAYS = WAYS,
  localparam int SW = $clog2(N_SETS),
  localparam int WW = $clog2(N_WAYS),
  localparam int IW = SW + WW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SW-1:0]                rd_set,
  output logic [N_WAYS-1:0][TAG_W-1:0] rd_tags,
  output logic [N_WAYS-1:0]            rd_valid,
  output logic [N_WAYS-1:0]            rd_lock,
  input  logic [SW-1:0]                dbg_set,
  input  logic [WW-1:0]                dbg_way,
  input  logic [WSEL_W-1:0]            dbg_word,
  output logic [TAG_W-1:0]             dbg_tag,
  output logic                         dbg_vbit,
  output logic                         dbg_lbit,
  output logic [WORD_W-1:0]            dbg_data,
  input  logic                         fill_en,
  input  logic [SW-1:0]                fill_set,
  input  logic [WW-1:0]                fill_way,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic [LINE_W-1:0]            fill_line,
  input  logic                         cmd_en,
  input  line_op_e                     cmd_op,
  input  logic [SW-1:0]                cmd_set,
  input  logic [WW-1:0]                cmd_way
);
  localparam int ENTRIES = N_SETS * N_WAYS;

  logic [TAG_W-1:0]  tag_mem  [ENTRIES];
  logic [LINE_W-1:0] data_mem [ENTRIES];
  logic [ENTRIES-1:0] valid_q, lock_q;

  logic [IW-1:0] fill_idx, cmd_idx, dbg_idx;
  assign fill_idx = {fill_set, fill_way};
  assign cmd_idx  = {cmd_set, cmd_way};
  assign dbg_idx  = {dbg_set, dbg_way};

  for (genvar w = 0; w < N_WAYS; w++) begin : g_rd
    assign rd_tags[w]  = tag_mem[{rd_set, WW'(w)}];
    assign rd_valid[w] = valid_q[{rd_set, WW'(w)}];
    assign rd_lock[w]  = lock_q[{rd_set, WW'(w)}];
  end

  logic [LINE_W-1:0] dbg_line;
  assign dbg_tag  = tag_mem[dbg_idx];
  assign dbg_vbit = valid_q[dbg_idx];
  assign dbg_lbit = lock_q[dbg_idx];
  assign dbg_line = data_mem[dbg_idx];
  assign dbg_data = dbg_line[dbg_word*WORD_W +: WORD_W];

  // state: fill first, then the command, so a command on the same line wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) tag_mem[i] <= '0;
    end else begin
      if (fill_en) begin
        tag_mem[fill_idx] <= fill_tag;
        valid_q[fill_idx] <= 1'b1;
        lock_q[fill_idx]  <= 1'b0;
      end
      if (cmd_en) begin
        case (cmd_op)
          OP_LOCK:   lock_q[cmd_idx] <= 1'b1;
          OP_UNLOCK: lock_q[cmd_idx] <= 1'b0;
          OP_INVAL: begin
            valid_q[cmd_idx] <= 1'b0;
            lock_q[cmd_idx]  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) data_mem[fill_idx] <= fill_line;
  end

  // R9: a fill leaves its line valid and unlocked unless a command hit it too
  assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !(cmd_en && cmd_idx == fill_idx) |=> valid_q[$past(fill_idx)] && !lock_q[$past(fill_idx)])
    else $error("assert_fill_state_R9");
endmodule

// File: rtl/ictag_lru.sv
module ictag_lru
  import ictag_pkg::*;
#(
  parameter int N_SETS = SETS,
  localparam int SW = $clog2(N_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    lk_set,
  output lru_t             lk_code,
  input  logic [SW-1:0]    dbg_set,
  output lru_t             dbg_code,
  input  logic             hit_en,
  input  logic [SW-1:0]    hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [SW-1:0]    fill_set,
  input  logic [WAY_W-1:0] fill_way
);
  lru_t lru_mem [N_SETS];

  logic same_set;
  assign same_set = hit_en && fill_en && (hit_set == fill_set);

  assign lk_code  = lru_mem[lk_set];
  assign dbg_code = lru_mem[dbg_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SETS; s++) lru_mem[s] <= '0;
    end else begin
      if (hit_en && !same_set)
        lru_mem[hit_set] <= lru_touch(lru_mem[hit_set], int'(hit_way));
      if (fill_en)
        lru_mem[fill_set] <= same_set
          ? lru_touch(lru_touch(lru_mem[fill_set], int'(hit_way)), int'(fill_way))
          : lru_touch(lru_mem[fill_set], int'(fill_way));
    end
  end

  assert property (@(posedge clk) disable iff (!rst_n)
    hit_en && !same_set |=> beats_all_but(lru_mem[$past(hit_set)], int'($past(hit_way)), int'($past(hit_way))))
    else $error("assert_hit_newest_R4");

  assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> beats_all_but(lru_mem[$past(fill_set)], int'($past(fill_way)), int'($past(fill_way))))
    else $error("assert_fill_newest_R4");

  assert property (@(posedge clk) disable iff (!rst_n)
    same_set && hit_way != fill_way |=>
      beats_all_but(lru_mem[$past(fill_set)], int'($past(hit_way)), int'($past(fill_way))))
    else $error("assert_hit_second_R12");
endmodule

// File: rtl/ictag_victim.sv
module ictag_victim
  import ictag_pkg::*;
(
  input  logic [WAYS-1:0]  valid_row,
  input  logic [WAYS-1:0]  lock_row,
  input  lru_t             code,
  output logic [WAY_W-1:0] victim,
  output logic             noalloc
);
  logic [WAYS-1:0] free_mask, empty_mask;
  assign free_mask  = ~lock_row;
  assign empty_mask = ~valid_row & ~lock_row;

  always_comb begin
    logic found;
    logic oldest;
    found   = 1'b0;
    victim  = '0;
    noalloc = ~|free_mask;
    for (int w = 0; w < WAYS; w++)
      if (!found && empty_mask[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    for (int w = 0; w < WAYS; w++) begin
      oldest = free_mask[w];
      for (int c = 0; c < WAYS; c++)
        if (c != w && free_mask[c] && !way_newer(code, c, w)) oldest = 1'b0;
      if (!found && oldest) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/icache_tag_store.sv
module icache_tag_store
  import ictag_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [ADDR_W-1:0]   lk_addr,
  input  logic [TAG_W-1:0]    lk_ptag,
  output logic                lk_done,
  output logic                lk_hit,
  output logic [WAY_W-1:0]    lk_hit_way,
  output logic [WAY_W-1:0]    lk_victim,
  output logic                lk_noalloc,
  input  logic                fill_valid,
  input  logic [SET_W-1:0]    fill_set,
  input  logic [WAY_W-1:0]    fill_way,
  input  logic [TAG_W-1:0]    fill_tag,
  input  logic [LINE_W-1:0]   fill_line,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [SET_W-1:0]    cmd_set,
  input  logic [WAY_W-1:0]    cmd_way,
  input  logic                dbg_valid,
  input  logic [DBG_W-1:0]    dbg_cmd,
  output logic                dbg_done,
  output logic [WORD_W-1:0]   dbg_rdata
);
  // address split and debug command fields
  logic [SET_W-1:0]  lk_set;
  logic [ADDR_W-SET_W-1:0] unused_addr_bits;
  logic              dbg_sel;
  logic [WAY_W-1:0]  dbg_way;
  logic [SET_W-1:0]  dbg_set;
  logic [WSEL_W-1:0] dbg_word;

  assign lk_set           = lk_addr[SET_LSB +: SET_W];
  assign unused_addr_bits = {lk_addr[ADDR_W-1:SET_LSB+SET_W], lk_addr[SET_LSB-1:0]};
  assign {dbg_sel, dbg_way, dbg_set, dbg_word} = dbg_cmd;

  // named internal events
  logic [WAYS-1:0][TAG_W-1:0] tag_row;
  logic [WAYS-1:0] valid_row, lock_row, hit_vec;
  logic            hit_any, hit_touch;
  logic [WAY_W-1:0] hit_way_c, victim_c;
  logic            noalloc_c;
  lru_t            lk_code, dbg_code;
  logic [TAG_W-1:0] dbg_tag;
  logic            dbg_vbit, dbg_lbit;
  logic [WORD_W-1:0] dbg_data;

  ictag_lines u_lines (
    .clk, .rst_n,
    .rd_set(lk_set), .rd_tags(tag_row), .rd_valid(valid_row), .rd_lock(lock_row),
    .dbg_set, .dbg_way, .dbg_word, .dbg_tag, .dbg_vbit, .dbg_lbit, .dbg_data,
    .fill_en(fill_valid), .fill_set, .fill_way, .fill_tag, .fill_line,
    .cmd_en(cmd_valid), .cmd_op(line_op_e'(cmd_op)), .cmd_set, .cmd_way
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_row[w] && (tag_row[w] == lk_ptag);
  end

  always_comb begin
    hit_way_c = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way_c = WAY_W'(w);
  end
  assign hit_any   = |hit_vec;
  assign hit_touch = lk_valid && hit_any;

  ictag_lru u_lru (
    .clk, .rst_n,
    .lk_set, .lk_code, .dbg_set, .dbg_code,
    .hit_en(hit_touch), .hit_set(lk_set), .hit_way(hit_way_c),
    .fill_en(fill_valid), .fill_set, .fill_way
  );

  ictag_victim u_victim (
    .valid_row, .lock_row, .code(lk_code),
    .victim(victim_c), .noalloc(noalloc_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_done    <= 1'b0;
      lk_hit     <= 1'b0;
      lk_hit_way <= '0;
      lk_victim  <= '0;
      lk_noalloc <= 1'b0;
      dbg_done   <= 1'b0;
      dbg_rdata  <= '0;
    end else begin
      lk_done    <= lk_valid;
      lk_hit     <= hit_touch;
      lk_hit_way <= lk_valid ? hit_way_c : '0;
      lk_victim  <= lk_valid ? victim_c : '0;
      lk_noalloc <= lk_valid && noalloc_c;
      dbg_done   <= dbg_valid;
      if (dbg_valid)
        dbg_rdata <= dbg_sel ? dbg_data
                             : {dbg_tag, 2'b00, dbg_vbit, dbg_lbit, 2'b00, dbg_code};
    end
  end

  assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> lk_done)
    else $error("assert_lookup_latency_R3");

  assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && hit_any |-> valid_row[hit_way_c] && tag_row[hit_way_c] == lk_ptag)
    else $error("assert_hit_match_R3");

  assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && |(~valid_row & ~lock_row) |-> !valid_row[victim_c] && !lock_row[victim_c])
    else $error("assert_empty_first_R5");

  assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !noalloc_c |-> !lock_row[victim_c])
    else $error("assert_victim_unlocked_R6");

  assert property (@(posedge clk) disable iff (!rst_n) lk_noalloc |-> lk_victim == '0)
    else $error("assert_noalloc_victim_R7");

  assert property (@(posedge clk) disable iff (!rst_n) dbg_valid |=> dbg_done)
    else $error("assert_debug_latency_R10");
endmodule

// File: tb/icache_tag_store_tb.sv
module icache_tag_store_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         lk_valid = 0, fill_valid = 0, cmd_valid = 0, dbg_valid = 0;
  logic [31:0]  lk_addr = '0;
  logic [19:0]  lk_ptag = '0, fill_tag = '0;
  logic [7:0]   fill_set = '0, cmd_set = '0;
  logic [1:0]   fill_way = '0, cmd_way = '0, cmd_op = '0;
  logic [127:0] fill_line = '0;
  logic [12:0]  dbg_cmd = '0;
  logic         lk_done, lk_hit, lk_noalloc, dbg_done;
  logic [1:0]   lk_hit_way, lk_victim;
  logic [31:0]  dbg_rdata;

  icache_tag_store u_dut (.*);

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model: age rank per way, 0 = newest
  logic [19:0]  m_tag [256][4];
  logic         m_val [256][4];
  logic         m_lck [256][4];
  int           m_age [256][4];
  logic [127:0] m_data [256][4];

  function automatic logic [5:0] m_code(int s);
    logic [5:0] c;
    c[0] = m_age[s][1] < m_age[s][0];
    c[1] = m_age[s][2] < m_age[s][0];
    c[2] = m_age[s][2] < m_age[s][1];
    c[3] = m_age[s][3] < m_age[s][0];
    c[4] = m_age[s][3] < m_age[s][1];
    c[5] = m_age[s][3] < m_age[s][2];
    return c;
  endfunction

  task automatic m_touch(int s, int w);
    int old = m_age[s][w];
    for (int c = 0; c < 4; c++) if (m_age[s][c] < old) m_age[s][c]++;
    m_age[s][w] = 0;
  endtask

  task automatic m_victim(int s, output logic [1:0] v, output logic na);
    int best = -1;
    na = m_lck[s][0] && m_lck[s][1] && m_lck[s][2] && m_lck[s][3];
    v = 2'd0;
    if (!na) begin
      for (int w = 3; w >= 0; w--) if (!m_lck[s][w] && !m_val[s][w]) best = w;
      if (best < 0)
        for (int w = 0; w < 4; w++)
          if (!m_lck[s][w] && (best < 0 || m_age[s][w] > m_age[s][best])) best = w;
      v = 2'(best);
    end
  endtask

  // scoreboard queues
  logic [5:0]  lk_q[$];
  string       lk_rq[$];
  logic [31:0] dbg_q[$];
  string       dbg_rq[$];

  // pending stimulus for the next cycle
  bit p_lk, p_fill, p_cmd, p_dbg;
  logic [31:0] p_addr; logic [19:0] p_ptag, p_ftag;
  logic [7:0] p_fset, p_cset; logic [1:0] p_fway, p_cway, p_op;
  logic [127:0] p_line; logic [12:0] p_dcmd;
  string p_req = "R3";

  task automatic set_lk(logic [31:0] a, logic [19:0] t);
    p_lk = 1; p_addr = a; p_ptag = t;
  endtask
  task automatic set_fill(int s, int w, logic [19:0] t);
    p_fill = 1; p_fset = 8'(s); p_fway = 2'(w); p_ftag = t;
    for (int k = 0; k < 4; k++) p_line[k*32 +: 32] = {8'(s), 8'(w), 8'(k), t[7:0]};
  endtask
  task automatic set_cmd(int op, int s, int w);
    p_cmd = 1; p_op = 2'(op); p_cset = 8'(s); p_cway = 2'(w);
  endtask
  task automatic set_dbg(bit sel, int w, int s, int k);
    p_dbg = 1; p_dcmd = {sel, 2'(w), 8'(s), 2'(k)};
  endtask

  task automatic tick();
    int s; logic h; logic [1:0] hw, v; logic na;
    lk_valid = p_lk; lk_addr = p_addr; lk_ptag = p_ptag;
    fill_valid = p_fill; fill_set = p_fset; fill_way = p_fway; fill_tag = p_ftag; fill_line = p_line;
    cmd_valid = p_cmd; cmd_op = p_op; cmd_set = p_cset; cmd_way = p_cway;
    dbg_valid = p_dbg; dbg_cmd = p_dcmd;
    h = 0; hw = 0; s = int'(p_addr[11:4]);
    if (p_lk) begin
      for (int w = 3; w >= 0; w--)
        if (m_val[s][w] && m_tag[s][w] == p_ptag) begin h = 1; hw = 2'(w); end
      m_victim(s, v, na);
      lk_q.push_back({h, hw, v, na}); lk_rq.push_back(p_req);
    end
    if (p_dbg) begin
      int ds = int'(p_dcmd[9:2]); int dw = int'(p_dcmd[11:10]); int dk = int'(p_dcmd[1:0]);
      if (p_dcmd[12]) dbg_q.push_back(m_data[ds][dw][dk*32 +: 32]);
      else dbg_q.push_back({m_tag[ds][dw], 2'b00, m_val[ds][dw], m_lck[ds][dw], 2'b00, m_code(ds)});
      dbg_rq.push_back(p_req);
    end
    if (p_lk && h) m_touch(s, int'(hw));
    if (p_fill) begin
      m_tag[p_fset][p_fway] = p_ftag; m_val[p_fset][p_fway] = 1; m_lck[p_fset][p_fway] = 0;
      m_data[p_fset][p_fway] = p_line; m_touch(int'(p_fset), int'(p_fway));
    end
    if (p_cmd) case (p_op)
      2'd1: m_lck[p_cset][p_cway] = 1;
      2'd2: m_lck[p_cset][p_cway] = 0;
      2'd3: begin m_val[p_cset][p_cway] = 0; m_lck[p_cset][p_cway] = 0; end
      default: ;
    endcase
    @(negedge clk);
    p_lk = 0; p_fill = 0; p_cmd = 0; p_dbg = 0;
    lk_valid = 0; fill_valid = 0; cmd_valid = 0; dbg_valid = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (lk_done) begin
        if (lk_q.size() == 0) chk("R3 unexpected lookup result", 1, 0);
        else chk(lk_rq.pop_front(), {lk_hit, lk_hit_way, lk_victim, lk_noalloc}, lk_q.pop_front());
      end
      if (dbg_done) begin
        if (dbg_q.size() == 0) chk("R10 unexpected debug result", 1, 0);
        else chk(dbg_rq.pop_front(), dbg_rdata, dbg_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam int S = 8'h12;
  logic [31:0] rng = 32'h1234_5678;
  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5; return x;
  endfunction

  initial begin
    for (int s = 0; s < 256; s++)
      for (int w = 0; w < 4; w++) begin
        m_tag[s][w] = '0; m_val[s][w] = 0; m_lck[s][w] = 0; m_age[s][w] = w; m_data[s][w] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state at the ports
    chk("R1 outputs", {lk_done, lk_hit, lk_hit_way, lk_victim, lk_noalloc, dbg_done, dbg_rdata}, 0);
    p_req = "R1"; set_dbg(0, 2, 5, 0); tick();
    p_req = "R5"; set_lk({20'hABCDE, 8'(S), 4'h0}, 20'h01000); tick();
    // fill all four ways (R9), then hit each
    for (int w = 0; w < 4; w++) begin set_fill(S, w, 20'h01000 + 20'(w)); tick(); end
    p_req = "R9";
    for (int w = 3; w >= 0; w--) begin set_lk({20'h0, 8'(S), 4'h0}, 20'h01000 + 20'(w)); tick(); end
    // R2: upper and low address bits ignored; other set misses
    p_req = "R2";
    set_lk({20'hFFFFF, 8'(S), 4'hF}, 20'h01002); tick();
    set_lk({20'h01002, 8'(S + 1), 4'h0}, 20'h01002); tick();
    // R4 / R10: recency code and tag word
    p_req = "R10"; set_dbg(0, 2, S, 0); tick();
    p_req = "R4"; set_dbg(0, 0, S, 3); tick();
    // R6: least recent way chosen; R8 lock skips it
    p_req = "R6"; set_lk({20'h0, 8'(S), 4'h4}, 20'h0BEEF); tick();
    p_req = "R8"; set_cmd(1, S, 3); tick();
    set_lk({20'h0, 8'(S), 4'h0}, 20'h0BEEF); tick();
    set_dbg(0, 3, S, 0); tick();
    // R7: all locked
    for (int w = 0; w < 3; w++) begin set_cmd(1, S, w); tick(); end
    p_req = "R7"; set_lk({20'h0, 8'(S), 4'h0}, 20'h01001); tick();
    p_req = "R6"; set_cmd(2, S, 1); tick();
    set_lk({20'h0, 8'(S), 4'h0}, 20'h0BEEF); tick();
    // R8 invalidate: line misses and becomes the empty victim (R5)
    p_req = "R8"; set_cmd(2, S, 3); tick();
    set_cmd(3, S, 3); tick();
    set_lk({20'h0, 8'(S), 4'h0}, 20'h01003); tick();
    p_req = "R5"; set_cmd(3, S, 0); tick();
    set_lk({20'h0, 8'(S), 4'h0}, 20'h0BEEF); tick();
    // R11: data words
    p_req = "R11";
    for (int k = 0; k < 4; k++) begin set_dbg(1, 1, S, k); tick(); end
    set_dbg(1, 2, S, 3); tick();
    // R12: same-cycle lookup hit and fill in one set
    for (int w = 0; w < 4; w++) begin set_fill(8'h30, w, 20'h02000 + 20'(w)); tick(); end
    p_req = "R12";
    set_lk({20'h0, 8'h30, 4'h0}, 20'h02001); set_fill(8'h30, 2, 20'h03333); tick();
    set_dbg(0, 1, 8'h30, 0); tick();
    set_lk({20'h0, 8'h30, 4'h0}, 20'h02002); tick();
    set_lk({20'h0, 8'h30, 4'h0}, 20'h03333); tick();
    set_lk({20'h0, 8'h30, 4'h0}, 20'h02000); set_fill(8'h30, 0, 20'h04444); tick();
    set_lk({20'h0, 8'h30, 4'h0}, 20'h02000); set_dbg(0, 0, 8'h30, 0); tick();
    // R8: fill and command on the same line in one cycle
    p_req = "R8"; set_fill(8'h31, 1, 20'h05555); set_cmd(1, 8'h31, 1); tick();
    set_dbg(0, 1, 8'h31, 0); tick();
    // randomized mix on four sets
    p_req = "R3";
    for (int i = 0; i < 400; i++) begin
      int ls, fs; logic [19:0] lt, ft; logic [1:0] v; logic na; bit dup;
      rng = nxt(rng); ls = 8'h40 + int'(rng[1:0]); lt = 20'h00200 + 20'(rng[4:2] % 6);
      set_lk({rng[31:20], 8'(ls), rng[8:5]}, lt);
      rng = nxt(rng);
      if (rng[1:0] != 0) begin
        fs = 8'h40 + int'(rng[3:2]); ft = 20'h00200 + 20'(rng[6:4] % 6);
        dup = 0; for (int w = 0; w < 4; w++) if (m_val[fs][w] && m_tag[fs][w] == ft) dup = 1;
        m_victim(fs, v, na);
        if (!dup && !na) set_fill(fs, int'(v), ft);
      end
      rng = nxt(rng);
      if (rng[2:0] == 0) set_cmd(1 + int'(rng[4:3]) % 3, 8'h40 + int'(rng[6:5]), int'(rng[8:7]));
      rng = nxt(rng);
      if (rng[1:0] == 0) set_dbg(0, int'(rng[3:2]), 8'h40 + int'(rng[5:4]), 0);
      tick();
    end
    repeat (3) tick();
    chk("R3 lookup queue drained", lk_q.size(), 0);
    chk("R10 debug queue drained", dbg_q.size(), 0);
    finish_run();
  end
endmodule